// File: doc/BRIEF.md
# Configurable input cell array

This block sits between 24 incoming port pins and the internal logic input bus. The pins form three 8-bit ports. Pin 2 of port 2 has no cell, so there are 23 working input cells. Each cell is configured on its own to do one of three things:

- pass its pin straight to the bus;
- hold the pin in a level-sensitive latch;
- capture the pin in an edge-triggered register.

The cells are grouped by nibble, four pins per group. Each group shares one enable. A per-group selector takes that enable either from a logic control term or from the CPU address-latch strobe. With the strobe selected, the group captures the upper address bits that a multiplexed bus drives onto the pins. The CPU writes the mode and selector settings and reads back the cell outputs one port at a time.

The whole array runs on a single system clock. The group enables are sampled levels. A latch-mode cell loads its pin on every clock in which its group enable is high. A register-mode cell loads only on the clock in which the sampled enable goes from low to high. A held value reaches the bus one clock after it is loaded. A pass-through cell drives the bus combinationally.

Top module: `iomc_array`

## Requirements
- R1: After reset, every cell is in pass-through mode and every group selects its logic term. The bus therefore equals the pins, with the missing pin at 0.
- R2: Mode code 0 and mode code 3 both give pass-through. The bus bit equals its pin in the same cycle, with no clock between them.
- R3: In mode code 1 (latch), on each clock where the group enable is high the cell loads its pin, and the bus shows that value from the next cycle. While the enable is low, the bus bit holds.
- R4: In mode code 2 (register), the cell loads its pin only on the clock where the sampled group enable rises from 0 to 1. It holds while the enable stays high, stays low or falls.
- R5: Group g covers bus bits 4g+3..4g, which are port g/2, low nibble for even g and high nibble for odd g. The enable of group g affects no cell in any other group.
- R6: Bit g of the select byte at config address 6 picks the enable source for group g: 1 selects the address strobe and 0 selects grp_term[g]. The source that is not selected has no effect.
- R7: A config write to address g, for g from 0 to 5, sets the modes of group g. Bits 2i+1..2i of the data go to the cell at bus bit 4g+i. A write to any address above 6 changes nothing.
- R8: With rd_addr equal to p, for p from 0 to 2, rd_data equals bus bits 8p+7..8p. With rd_addr equal to 3, rd_data is 0.
- R9: Bus bit 18, which is port 2 pin 2 and has no cell, and the matching rd_data bit 2 for port 2 always read 0, whatever the pin and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 24 | Port pins, port p at bits 8p+7..8p |
| grp_term | input | 6 | Logic control term per nibble group |
| addr_strobe | input | 1 | CPU address-latch strobe |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 4 | Config address: 0-5 group modes, 6 select byte |
| cfg_wdata | input | 8 | Config write data |
| rd_addr | input | 2 | Port index for CPU readback |
| rd_data | output | 8 | Cell outputs of the selected port |
| pld_bus | output | 24 | Cell outputs to the internal logic bus |

## Verification
The cells hold a single bit each, so a wrong held value, a wrong mode or a wrong group select shows on pld_bus within one clock. It can be seen only when the cell is in latch or register mode. The bench therefore puts each group into a storing mode, moves the pins while the enable is inactive, and expects the held value to persist. A bad edge detector gives a capture on a steady-high enable, which shows one cycle later. A decode error in the config map shows as a group that follows the wrong enable source.

// File: rtl/iomc_pkg.sv
package iomc_pkg;
    typedef enum logic [1:0] {
        MODE_PASS     = 2'd0,
        MODE_LATCH    = 2'd1,
        MODE_REG      = 2'd2,
        MODE_PASS_ALT = 2'd3
    } cell_mode_e;
endpackage

// File: rtl/iomc_cfg.sv
module iomc_cfg #(
    parameter int NPORTS    = 3,
    parameter int PORT_W    = 8,
    parameter int SKIP_PORT = 2,
    parameter int SKIP_BIT  = 2,
    parameter int AW        = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [AW-1:0]                addr,
    input  logic [PORT_W-1:0]            wdata,
    output logic [2*NPORTS*PORT_W-1:0]   mode_o,
    output logic [2*NPORTS-1:0]          sel_o
);
    localparam int NPIN     = NPORTS * PORT_W;
    localparam int NGRP     = NPORTS * 2;
    localparam int HALF     = PORT_W / 2;
    localparam int SKIP_IDX = SKIP_PORT * PORT_W + SKIP_BIT;

    typedef struct packed {
        logic [2*NPIN-1:0] mode;
        logic [NGRP-1:0]   sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            for (int g = 0; g < NGRP; g++) begin
                if (addr == AW'(g)) begin
                    for (int i = 0; i < HALF; i++) begin
                        cfg_d.mode[2*(g*HALF+i) +: 2] = wdata[2*i +: 2];
                    end
                end
            end
            if (addr == AW'(NGRP)) begin
                cfg_d.sel = wdata[NGRP-1:0];
            end
        end
        cfg_d.mode[2*SKIP_IDX +: 2] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_o = cfg_q.mode;
    assign sel_o  = cfg_q.sel;
endmodule

// File: rtl/iomc_grpctl.sv
module iomc_grpctl #(
    parameter int NGRP = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] grp_term,
    input  logic            addr_strobe,
    input  logic [NGRP-1:0] sel,
    output logic [NGRP-1:0] grp_en,
    output logic [NGRP-1:0] grp_rise
);
    typedef struct packed {
        logic [NGRP-1:0] prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            grp_en[g] = sel[g] ? addr_strobe : grp_term[g];
        end
        ctl_d.prev = grp_en;
        grp_rise   = grp_en & ~ctl_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/iomc_cell.sv
module iomc_cell
    import iomc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    input  logic       en,
    input  logic       rise,
    output logic       cell_out
);
    typedef struct packed {
        logic held;
    } cell_t;

    cell_t      cell_d, cell_q;
    cell_mode_e cur_mode;

    assign cur_mode = cell_mode_e'(mode);

    always_comb begin
        cell_d = cell_q;
        case (cur_mode)
            MODE_LATCH: if (en)   cell_d.held = pin;
            MODE_REG:   if (rise) cell_d.held = pin;
            default: ;
        endcase
        cell_out = (cur_mode == MODE_LATCH || cur_mode == MODE_REG) ? cell_q.held : pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end
endmodule

// File: rtl/iomc_rdmux.sv
module iomc_rdmux #(
    parameter int NPORTS = 3,
    parameter int PORT_W = 8,
    parameter int RD_AW  = 2
) (
    input  logic [NPORTS*PORT_W-1:0] bus,
    input  logic [RD_AW-1:0]         rd_addr,
    output logic [PORT_W-1:0]        rd_data
);
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (rd_addr == RD_AW'(p)) rd_data = bus[p*PORT_W +: PORT_W];
        end
    end
endmodule

// File: rtl/iomc_array.sv
module iomc_array #(
    parameter int NPORTS    = 3,
    parameter int PORT_W    = 8,
    parameter int SKIP_PORT = 2,
    parameter int SKIP_BIT  = 2,
    parameter int AW        = 4,
    parameter int RD_AW     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORTS*PORT_W-1:0]   pin_in,
    input  logic [2*NPORTS-1:0]        grp_term,
    input  logic                       addr_strobe,
    input  logic                       cfg_we,
    input  logic [AW-1:0]              cfg_addr,
    input  logic [PORT_W-1:0]          cfg_wdata,
    input  logic [RD_AW-1:0]           rd_addr,
    output logic [PORT_W-1:0]          rd_data,
    output logic [NPORTS*PORT_W-1:0]   pld_bus
);
    localparam int NPIN     = NPORTS * PORT_W;
    localparam int NGRP     = NPORTS * 2;
    localparam int HALF     = PORT_W / 2;
    localparam int SKIP_IDX = SKIP_PORT * PORT_W + SKIP_BIT;

    logic [2*NPIN-1:0] cell_mode;
    logic [NGRP-1:0]   grp_sel;
    logic [NGRP-1:0]   grp_en;
    logic [NGRP-1:0]   grp_rise;

    iomc_cfg #(
        .NPORTS(NPORTS), .PORT_W(PORT_W), .SKIP_PORT(SKIP_PORT),
        .SKIP_BIT(SKIP_BIT), .AW(AW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .mode_o(cell_mode), .sel_o(grp_sel)
    );

    iomc_grpctl #(.NGRP(NGRP)) u_grpctl (
        .clk(clk), .rst_n(rst_n), .grp_term(grp_term),
        .addr_strobe(addr_strobe), .sel(grp_sel),
        .grp_en(grp_en), .grp_rise(grp_rise)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_cell
        if (i == SKIP_IDX) begin : g_absent
            logic unused_absent;
            assign unused_absent = ^{pin_in[i], cell_mode[2*i +: 2]};
            assign pld_bus[i]    = 1'b0;
        end else begin : g_present
            iomc_cell u_cell (
                .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
                .mode(cell_mode[2*i +: 2]),
                .en(grp_en[i / HALF]), .rise(grp_rise[i / HALF]),
                .cell_out(pld_bus[i])
            );
        end
    end

    iomc_rdmux #(.NPORTS(NPORTS), .PORT_W(PORT_W), .RD_AW(RD_AW)) u_rdmux (
        .bus(pld_bus), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/iomc_array_chk.sv
module iomc_array_chk #(
    parameter int NPORTS    = 3,
    parameter int PORT_W    = 8,
    parameter int SKIP_PORT = 2,
    parameter int SKIP_BIT  = 2,
    parameter int RD_AW     = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NPORTS*PORT_W-1:0]   pin_in,
    input logic [NPORTS*PORT_W-1:0]   pld_bus,
    input logic [2*NPORTS*PORT_W-1:0] cell_mode,
    input logic [2*NPORTS-1:0]        grp_sel,
    input logic [2*NPORTS-1:0]        grp_en,
    input logic [2*NPORTS-1:0]        grp_rise,
    input logic [RD_AW-1:0]           rd_addr,
    input logic [PORT_W-1:0]          rd_data
);
    localparam int NPIN     = NPORTS * PORT_W;
    localparam int HALF     = PORT_W / 2;
    localparam int SKIP_IDX = SKIP_PORT * PORT_W + SKIP_BIT;

    logic unused_chk;
    assign unused_chk = ^{pin_in[SKIP_IDX], pld_bus[SKIP_IDX], cell_mode[2*SKIP_IDX +: 2]};

    // R1: the first sampled cycle out of reset sees the default configuration
    a_r1_reset_default: assert property (@(posedge clk)
        $rose(rst_n) |-> (cell_mode == '0 && grp_sel == '0));

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        if (i != SKIP_IDX) begin : g_live
            // R2
            a_r2_pass_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
                (cell_mode[2*i +: 2] == 2'd0 || cell_mode[2*i +: 2] == 2'd3)
                |-> pld_bus[i] == pin_in[i]);
            // R3
            a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (cell_mode[2*i +: 2] == 2'd1 && !grp_en[i / HALF])
                |=> (cell_mode[2*i +: 2] != 2'd1 || $stable(pld_bus[i])));
            // R4
            a_r4_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (cell_mode[2*i +: 2] == 2'd2 && !grp_rise[i / HALF])
                |=> (cell_mode[2*i +: 2] != 2'd2 || $stable(pld_bus[i])));
        end
    end

    // R8
    a_r8_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= NPORTS) |-> rd_data == '0);

    // R9
    a_r9_missing_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == RD_AW'(SKIP_PORT)) |-> rd_data[SKIP_BIT] == 1'b0);
endmodule

bind iomc_array iomc_array_chk #(
    .NPORTS(NPORTS), .PORT_W(PORT_W), .SKIP_PORT(SKIP_PORT),
    .SKIP_BIT(SKIP_BIT), .RD_AW(RD_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pld_bus(pld_bus),
    .cell_mode(cell_mode), .grp_sel(grp_sel), .grp_en(grp_en),
    .grp_rise(grp_rise), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/iomc_array_bench.sv
module iomc_array_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] pin_in;
    logic [5:0]  grp_term;
    logic        addr_strobe;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [1:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [23:0] pld_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit          q_kind[$];
    logic [23:0] q_exp[$];
    logic [23:0] q_mask[$];
    string       q_req[$];

    iomc_array u_iomc_array (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .grp_term(grp_term),
        .addr_strobe(addr_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .pld_bus(pld_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                bit          k;
                logic [23:0] e, m, a;
                string       r;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                m = q_mask.pop_front();
                r = q_req.pop_front();
                a = k ? {16'h0, rd_data} : (pld_bus & m);
                n_checks++;
                if (a !== (e & m)) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", r, a, e & m);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_bus(input logic [23:0] e, input logic [23:0] m, input string r);
        q_kind.push_back(1'b0); q_exp.push_back(e); q_mask.push_back(m); q_req.push_back(r);
        wait (q_exp.size() == 0);
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] e, input string r);
        rd_addr = a;
        q_kind.push_back(1'b1); q_exp.push_back({16'h0, e}); q_mask.push_back(24'hFFFFFF);
        q_req.push_back(r);
        wait (q_exp.size() == 0);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_in = '0; grp_term = '0; addr_strobe = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; rd_addr = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 / R9: default pass-through, missing bit 18 reads 0
        pin_in = 24'hA5C3F0;
        expect_bus(24'hA1C3F0, 24'hFFFFFF, "R1");
        // R2: pass-through follows a new pattern with no clock
        pin_in = 24'h5A3C96;
        expect_bus(24'h5A3C96, 24'hFFFFFF, "R2");
        // R2: mode code 3 is also pass-through
        cfg_write(4'd0, 8'hFF);
        pin_in = 24'h00000F;
        expect_bus(24'h00000F, 24'h00000F, "R2 code3");

        // R3: latch on group 0
        cfg_write(4'd0, 8'h55);
        grp_term = 6'b000001; pin_in = 24'h000009;
        tick();
        expect_bus(24'h000009, 24'h00000F, "R3 load");
        grp_term = 6'b000000; pin_in = 24'h000006;
        tick();
        expect_bus(24'h000009, 24'h0000FF, "R3 hold");
        grp_term = 6'b000001;
        tick();
        expect_bus(24'h000006, 24'h00000F, "R3 reload");

        // R4 / R7: register on group 1 (config address 1)
        cfg_write(4'd1, 8'hAA);
        grp_term = 6'b000000; pin_in = 24'h000030;
        tick();
        expect_bus(24'h000000, 24'h0000F0, "R4 no edge");
        grp_term = 6'b000010;
        tick();
        expect_bus(24'h000030, 24'h0000F0, "R4 rise");
        pin_in = 24'h0000C0;
        tick();
        expect_bus(24'h000030, 24'h0000F0, "R4 steady high");
        grp_term = 6'b000000;
        tick();
        expect_bus(24'h000030, 24'h0000F0, "R4 fall");
        grp_term = 6'b000010;
        tick();
        expect_bus(24'h0000C0, 24'h0000F0, "R4 second rise");
        expect_bus(24'h000006, 24'h00000F, "R3 group0 untouched");

        // R5: group isolation on port 1
        cfg_write(4'd2, 8'h55);
        grp_term = 6'b000000; pin_in = 24'h000500;
        tick();
        expect_bus(24'h000000, 24'h000F00, "R5 closed");
        grp_term = 6'b001000;
        tick();
        expect_bus(24'h000000, 24'h000F00, "R5 neighbour term");
        grp_term = 6'b000100;
        tick();
        expect_bus(24'h000500, 24'h000F00, "R5 own term");

        // R6: group 4 register, clocked from the address strobe
        cfg_write(4'd4, 8'hAA);
        cfg_write(4'd6, 8'h10);
        grp_term = 6'b000000; addr_strobe = 1'b0; pin_in = 24'h0F0000;
        tick();
        grp_term = 6'b010000;
        tick();
        expect_bus(24'h000000, 24'h0F0000, "R6 term ignored");
        grp_term = 6'b000000; addr_strobe = 1'b1;
        tick();
        expect_bus(24'h0B0000, 24'h0F0000, "R6 strobe capture");
        pin_in = 24'h000000;
        tick();
        expect_bus(24'h0B0000, 24'h0F0000, "R6 strobe held");

        // R7: write above address 6 is ignored (group0 stays latch on its term)
        cfg_write(4'd7, 8'hFF);
        pin_in = 24'h00000A;
        tick();
        expect_bus(24'h000006, 24'h00000F, "R7 ignored write");

        // R8: per-port readback
        addr_strobe = 1'b0; pin_in = 24'hE47A5A;
        tick();
        expect_rd(2'd0, 8'hC6, "R8 port0");
        expect_rd(2'd1, 8'h75, "R8 port1");
        expect_rd(2'd2, 8'hEB, "R8 port2");
        expect_rd(2'd3, 8'h00, "R8 out of range");

        // R9: missing pin is 0 in pass-through readback
        cfg_write(4'd4, 8'h00);
        expect_rd(2'd2, 8'hE0, "R9 readback");
        expect_bus(24'h000000, 24'h040000, "R9 bus");

        done = 1;
        summary();
        $finish;
    end
endmodule